// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus Port

This block keeps a parameterised word (8 bits by default) in edge-triggered flops. A two-bit mode input picks one of four operations on each rising clock edge: keep the word, move it one place toward the most significant end, move it one place toward the least significant end, or take a new word from the parallel bus. An active-low clear acts at once, without a clock edge, and sets every bit to zero.

The parallel port is one shared bus, modelled here as split signals: `bus_in` is what the bus currently carries and `bus_out` with `bus_oe` is this block's three-state driver. The driver is on only when both active-low enables are low and the mode is not a load. Because a load always turns the driver off, the bus is free for another agent to supply the new word. The lowest and highest bits also leave the block as serial tail outputs that are always driven. Wiring one register's tail into the next register's serial input chains several registers into a longer shifter.

The design has no sequencer. The "state" is the word itself, and the mode code names the transition taken on each edge. KEEP (00) loops the word back unchanged. UP (01) brings in the low-end serial bit and moves each bit one place higher. DOWN (10) brings in the high-end serial bit and moves each bit one place lower. LOAD (11) replaces the word with the bus value. CLEAR is asynchronous and leads from any state back to all zeros.

Top module: `ushift_bus_reg`

## Requirements
- R1: While `clr_n` is low, the word is zero. With both enables low and mode 00, the block then shows `bus_oe`=1, `bus_out`=0 and both tails at 0.
- R2: With `mode_sel`=2'b00, a rising edge leaves the word unchanged.
- R3: With `mode_sel`=2'b01, a rising edge puts `ser_up_in` into bit 0 and moves each bit n to bit n+1. The old top bit is lost.
- R4: With `mode_sel`=2'b10, a rising edge puts `ser_dn_in` into the top bit and moves each bit n to bit n-1. The old bit 0 is lost.
- R5: With `mode_sel`=2'b11, a rising edge copies `bus_in` into the word.
- R6: Driving `clr_n` low zeroes the word immediately, with no clock edge needed. While it stays low it overrides any mode, including load, on later edges.
- R7: If `en_a_n` or `en_b_n` is high, `bus_oe` is 0.
- R8: If `mode_sel`=2'b11, `bus_oe` is 0 whatever the enables are, so the block never drives the bus while it loads.
- R9: If both enables are low and the mode is not 11, `bus_oe` is 1 and `bus_out` equals the word.
- R10: Keep, shift, load and clear change the word in the same way while the bus driver is off.
- R11: `tail_lo` always equals bit 0 of the word and `tail_hi` always equals the top bit, whatever the enables and the mode are.
- R12: Two instances chained through their tails act as one 16-bit register that shifts correctly in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all changes except clear happen on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation code: 00 keep, 01 up, 10 down, 11 load |
| ser_up_in | input | 1 | Serial bit that enters bit 0 in mode 01 |
| ser_dn_in | input | 1 | Serial bit that enters the top bit in mode 10 |
| en_a_n | input | 1 | Bus driver enable, active low |
| en_b_n | input | 1 | Second bus driver enable, active low |
| bus_in | input | WIDTH | Value currently on the shared bus |
| bus_out | output | WIDTH | Value this block drives onto the bus; zero when not driving |
| bus_oe | output | 1 | High when this block drives the bus |
| tail_lo | output | 1 | Bit 0 of the word, always driven |
| tail_hi | output | 1 | Top bit of the word, always driven |

## Verification
Directed sequences come first. A load of 8'hA5 followed by shifts shows whether bits travel in the right direction and whether the serial input enters at the correct end. Shifts run with the driver disabled and are then revealed by enabling it, which separates a register that really operates while the bus is off from one that only freezes its output. After that, a few hundred random vectors mix all four modes, random enables and random values from an outside bus driver, and a reference model in the bench predicts each result. A clear pulse placed between clock edges, then held across a load edge, shows that clear needs no clock and wins over the mode. Last, two chained instances shift a 16-bit word up and down to show that the tails pass bits across the seam.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_UP   = 2'b01,
        OP_DN   = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

endpackage

// File: rtl/usr_mode_dec.sv
module usr_mode_dec
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output op_e        op,
    output logic       load_sel
);

    always_comb begin
        unique case (mode_sel)
            2'b00:   op = OP_KEEP;
            2'b01:   op = OP_UP;
            2'b10:   op = OP_DN;
            default: op = OP_LOAD;
        endcase
    end

    always_comb begin
        load_sel = (op == OP_LOAD);
    end

endmodule

// File: rtl/usr_bit_cell.sv
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  op_e  op,
    input  logic from_below,
    input  logic from_above,
    input  logic bus_bit,
    output logic q
);

    logic q_nxt;

    always_comb begin
        unique case (op)
            OP_KEEP: q_nxt = q;
            OP_UP:   q_nxt = from_below;
            OP_DN:   q_nxt = from_above;
            OP_LOAD: q_nxt = bus_bit;
            default: q_nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/usr_bus_drv.sv
module usr_bus_drv #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic             load_sel,
    output logic             bus_oe,
    output logic [WIDTH-1:0] bus_out
);

    always_comb begin
        bus_oe  = !en_a_n && !en_b_n && !load_sel;
        bus_out = bus_oe ? q : '0;
    end

endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic             en_a_n,
    input  logic             en_b_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             tail_lo,
    output logic             tail_hi
);

    localparam int TOP = WIDTH - 1;

    op_e              op;
    logic             load_sel;
    logic [WIDTH-1:0] q;

    usr_mode_dec u_dec (
        .mode_sel (mode_sel),
        .op       (op),
        .load_sel (load_sel)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic below_b;
        logic above_b;
        if (i == 0) begin : g_lo_end
            assign below_b = ser_up_in;
        end else begin : g_lo_mid
            assign below_b = q[i-1];
        end
        if (i == TOP) begin : g_hi_end
            assign above_b = ser_dn_in;
        end else begin : g_hi_mid
            assign above_b = q[i+1];
        end
        usr_bit_cell u_cell (
            .clk        (clk),
            .clr_n      (clr_n),
            .op         (op),
            .from_below (below_b),
            .from_above (above_b),
            .bus_bit    (bus_in[i]),
            .q          (q[i])
        );
    end

    usr_bus_drv #(.WIDTH(WIDTH)) u_drv (
        .q        (q),
        .en_a_n   (en_a_n),
        .en_b_n   (en_b_n),
        .load_sel (load_sel),
        .bus_oe   (bus_oe),
        .bus_out  (bus_out)
    );

    assign tail_lo = q[0];
    assign tail_hi = q[TOP];

endmodule

// File: rtl/usr_checker.sv
module usr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode_sel,
    input logic             ser_up_in,
    input logic             ser_dn_in,
    input logic             en_a_n,
    input logic             en_b_n,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic [WIDTH-1:0] q
);

    always @(posedge clk) begin
        if (!clr_n) begin
            AST_CLR_ZERO: assert (q == '0) else $error("word not zero under clear"); // R1
        end
    end

    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b00 |=> $stable(q)); // R2

    AST_UP_SHIFT: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b01 |=> q == {$past(q[WIDTH-2:0]), $past(ser_up_in)}); // R3

    AST_DN_SHIFT: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b10 |=> q == {$past(ser_dn_in), $past(q[WIDTH-1:1])}); // R4

    AST_LOAD_TAKE: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |=> q == $past(bus_in)); // R5

    AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!clr_n)
        (en_a_n || en_b_n) |-> !bus_oe); // R7

    AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!clr_n)
        mode_sel == 2'b11 |-> !bus_oe); // R8

    AST_DRIVE_WORD: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_a_n && !en_b_n && mode_sel != 2'b11) |-> (bus_oe && bus_out == q)); // R9

endmodule

bind ushift_bus_reg usr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .mode_sel  (mode_sel),
    .ser_up_in (ser_up_in),
    .ser_dn_in (ser_dn_in),
    .en_a_n    (en_a_n),
    .en_b_n    (en_b_n),
    .bus_in    (bus_in),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe),
    .q         (q)
);

// File: tb/ushift_bus_reg_bench.sv
`timescale 1ns/1ps
module ushift_bus_reg_bench;

    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         clr_n;
    logic [1:0]   mode;
    logic         sup, sdn, ea_n, eb_n;
    logic         ext_en;
    logic [W-1:0] ext_val;
    logic [W-1:0] bus_net, d_out;
    logic         d_oe, t_lo, t_hi;

    // resolved bus: block driver, else outside driver, else pull-up
    always_comb bus_net = d_oe ? d_out : (ext_en ? ext_val : '1);

    ushift_bus_reg #(.WIDTH(W)) u_ushift_bus_reg (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode),
        .ser_up_in(sup), .ser_dn_in(sdn),
        .en_a_n(ea_n), .en_b_n(eb_n), .bus_in(bus_net),
        .bus_out(d_out), .bus_oe(d_oe), .tail_lo(t_lo), .tail_hi(t_hi)
    );

    // two-stage chain (R12)
    logic [1:0]  c_mode;
    logic        c_ser;
    logic [15:0] c_ld;
    logic [W-1:0] lo_out, hi_out;
    logic lo_oe, hi_oe, lo_tl, lo_th, hi_tl, hi_th;

    ushift_bus_reg #(.WIDTH(W)) u_chain_lo (
        .clk(clk), .clr_n(clr_n), .mode_sel(c_mode),
        .ser_up_in(c_ser), .ser_dn_in(hi_tl),
        .en_a_n(1'b0), .en_b_n(1'b0), .bus_in(c_ld[7:0]),
        .bus_out(lo_out), .bus_oe(lo_oe), .tail_lo(lo_tl), .tail_hi(lo_th)
    );
    ushift_bus_reg #(.WIDTH(W)) u_chain_hi (
        .clk(clk), .clr_n(clr_n), .mode_sel(c_mode),
        .ser_up_in(lo_th), .ser_dn_in(c_ser),
        .en_a_n(1'b0), .en_b_n(1'b0), .bus_in(c_ld[15:8]),
        .bus_out(hi_out), .bus_oe(hi_oe), .tail_lo(hi_tl), .tail_hi(hi_th)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] exp_q;
    logic [15:0]  exp16;
    bit done = 0;

    function automatic logic [W-1:0] ref_next(logic [W-1:0] q, logic [1:0] m,
                                              logic su, logic sd, logic [W-1:0] b);
        case (m)
            2'b00:   return q;
            2'b01:   return {q[W-2:0], su};
            2'b10:   return {sd, q[W-1:1]};
            default: return b;
        endcase
    endfunction

    function automatic logic ref_oe(logic a, logic b, logic [1:0] m);
        return !a && !b && (m != 2'b11);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic apply(logic [1:0] m, logic su, logic sd, logic a, logic b,
                         logic xe, logic [W-1:0] xv, string tag);
        logic [W-1:0] bsamp;
        logic         oe_exp;
        mode = m; sup = su; sdn = sd; ea_n = a; eb_n = b; ext_en = xe; ext_val = xv;
        #1;
        oe_exp = ref_oe(a, b, m);
        chk((m == 2'b11) ? "R8" : "R7", {15'd0, d_oe}, {15'd0, oe_exp});
        bsamp = oe_exp ? exp_q : (xe ? xv : '1);
        @(posedge clk);
        exp_q = ref_next(exp_q, m, su, sd, bsamp);
        @(negedge clk);
        #1;
        chk("R11", {14'd0, t_hi, t_lo}, {14'd0, exp_q[W-1], exp_q[0]});
        if (oe_exp) chk(tag, {8'd0, d_out}, {8'd0, exp_q});
    endtask

    // read the word back through the bus with keep mode, enables low
    task automatic reveal(string tag);
        mode = 2'b00; ea_n = 1'b0; eb_n = 1'b0; ext_en = 1'b0;
        #1;
        chk(tag, {7'd0, d_oe, d_out}, {7'd0, 1'b1, exp_q});
        @(negedge clk);
    endtask

    task automatic chain_step(logic [1:0] m, logic s, logic [15:0] ld);
        c_mode = m; c_ser = s; c_ld = ld;
        @(posedge clk);
        case (m)
            2'b00:   exp16 = exp16;
            2'b01:   exp16 = {exp16[14:0], s};
            2'b10:   exp16 = {s, exp16[15:1]};
            default: exp16 = ld;
        endcase
        @(negedge clk);
        c_mode = 2'b00;
        #1;
        chk("R12", {hi_out, lo_out}, exp16);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clr_n = 1'b0; mode = 2'b00; sup = 0; sdn = 0; ea_n = 0; eb_n = 0;
        ext_en = 0; ext_val = '0; c_mode = 2'b00; c_ser = 0; c_ld = '0;
        exp_q = '0; exp16 = '0;
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state seen at the ports
        chk("R1", {5'd0, d_oe, t_hi, t_lo, d_out}, {5'd0, 1'b1, 1'b0, 1'b0, 8'h00});
        clr_n = 1'b1;
        @(negedge clk);

        // directed: load from the outside driver, enables low (R5, R8)
        apply(2'b11, 0, 0, 0, 0, 1, 8'hA5, "R5");
        reveal("R5");
        apply(2'b01, 1, 0, 0, 0, 0, 8'h00, "R3");
        apply(2'b01, 0, 0, 0, 0, 0, 8'h00, "R3");
        apply(2'b10, 0, 1, 0, 0, 0, 8'h00, "R4");
        apply(2'b00, 1, 1, 0, 0, 0, 8'h00, "R2");
        // R10: operations with the driver off, then revealed
        apply(2'b01, 1, 0, 1, 0, 0, 8'h00, "R10");
        apply(2'b10, 0, 0, 0, 1, 0, 8'h00, "R10");
        apply(2'b11, 0, 0, 1, 1, 1, 8'h3C, "R10");
        apply(2'b01, 1, 0, 1, 1, 0, 8'h00, "R10");
        reveal("R10");
        // load with no outside driver takes the pulled-up bus
        apply(2'b11, 0, 0, 0, 0, 0, 8'h00, "R5");
        reveal("R5");

        // R6: clear between edges, then held across a load edge
        apply(2'b11, 0, 0, 0, 0, 1, 8'h5A, "R5");
        mode = 2'b00; ea_n = 0; eb_n = 0; ext_en = 0;
        #2 clr_n = 1'b0;
        #1;
        chk("R6", {7'd0, t_hi, t_lo, d_out}, 16'h0000);
        exp_q = '0;
        mode = 2'b11; ext_en = 1; ext_val = 8'hFF;
        @(posedge clk);
        #1;
        mode = 2'b00; ext_en = 0;
        #1;
        chk("R6", {7'd0, t_hi, t_lo, d_out}, 16'h0000);
        @(negedge clk);
        clr_n = 1'b1;
        @(negedge clk);

        // constrained random mix
        for (int v = 0; v < 400; v++) begin
            logic [1:0] m;
            logic a, b;
            m = 2'($urandom_range(0, 3));
            a = ($urandom_range(0, 3) == 0);
            b = ($urandom_range(0, 3) == 0);
            apply(m, 1'($urandom), 1'($urandom), a, b,
                  (m == 2'b11) ? 1'b1 : 1'($urandom), 8'($urandom), mode_tag(m));
            if (a || b) reveal("R10");
        end

        // chained 16-bit shifter
        chain_step(2'b11, 0, 16'h8001);
        for (int k = 0; k < 20; k++) chain_step(2'b01, 1'($urandom), 16'h0);
        chain_step(2'b11, 0, 16'h1234);
        for (int k = 0; k < 20; k++) chain_step(2'b10, 1'($urandom), 16'h0);
        chain_step(2'b00, 1, 16'hFFFF);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule